// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block cleans up to twelve byte-wide groups of digital input lines. Each raw line first passes through a two-flop synchronizer. It then either goes straight to the output or through a stability filter. The filtered output follows the input only after the input has held its new level for a programmed number of timebase ticks. One interval value, counted in fixed ticks of 200 ns, governs every filtered line. A per-line enable bit chooses between the filtered path and the raw path.

A free-running prescaler divides the system clock down to the tick rate. Each line keeps its own tick counter, and that counter restarts whenever the input agrees with the filtered value again. Software configures the block through a byte-wide register port. The interval is spread over three byte registers. Each group of eight lines has its own enable mask register.

Top module: `glitch_filter`

## Requirements
- R1: The interval is 20 bits wide. Byte 0x08 holds bits 7:0, byte 0x09 holds bits 15:8, and bits 3:0 of byte 0x0A hold bits 19:16. The upper nibble of byte 0x0A reads as 0. After reset the interval reads 0.
- R2: Group p (p from 0 to NPORTS-1) has an enable mask at byte address 0x44 + 16·p. Bit k of that mask controls line din[8p+k]. Masks read back as written and are 0 after reset. Any other address reads 0, and a write to it changes no register and no output.
- R3: A line whose enable bit is 0 drives dout with din delayed by the two synchronizer flops. A change applied between two clock edges is visible after the second following edge.
- R4: For an enabled line with interval N > 0, dout keeps its old value until the synchronized input has differed from it for N ticks. It then takes the new value. An excursion lasting fewer than N-1 ticks never reaches dout.
- R5: A tick occurs once every TICK_DIV clocks (10 clocks is 200 ns at 50 MHz). A line's count restarts whenever its synchronized input equals its filtered output.
- R6: With interval 0, an enabled line follows din three clock edges after a change.
- R7: A single interval value applies to every enabled line in every group.
- R8: A write to the interval registers leaves every filtered output unchanged in the cycle of the write. The new value is used from the next comparison onward.
- R9: After reset, with din held at 0, every dout bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| din | input | NPORTS·8 | Raw asynchronous input lines |
| dout | output | NPORTS·8 | Filtered or bypassed lines |

## Verification
The two actions that can fall in one cycle are a rewrite of the shared interval and the commit decision of a line whose count is already pending. The bench first sets a long interval and lets a changed line accumulate a few ticks. It then writes a short interval. It samples dout right after the write edge and expects the old level. One edge later it expects the new level, because the pending count already exceeds the new interval. A second overlap, where an input toggles back before its count is reached, is provoked with a short pulse and judged by dout never moving.

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int NPORTS   = 12,
  parameter int IVW      = 20,
  parameter int TICK_DIV = 10,
  parameter logic [7:0] IV_BASE   = 8'h08,
  parameter logic [7:0] MASK_BASE = 8'h44
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [7:0]            reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  input  logic [NPORTS*8-1:0]   din,
  output logic [NPORTS*8-1:0]   dout
);
  localparam int NL = NPORTS * 8;
  localparam int NB = (IVW + 7) / 8;
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [8*NB-1:0] IVMASK = {8*NB{1'b1}} >> (8*NB - IVW);

  logic [8*NB-1:0] ival_p;
  logic [IVW-1:0]  ival;
  logic [7:0]      en_m [NPORTS];
  logic [NL-1:0]   en_flat;
  logic [NL-1:0]   s1, s2, filt;
  logic [PW-1:0]   pre;
  logic            tick;

  assign ival = ival_p[IVW-1:0];
  assign tick = (pre == PW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival_p <= '0;
    end else if (reg_we) begin
      for (int b = 0; b < NB; b++)
        if (reg_addr == IV_BASE + 8'(b))
          ival_p[8*b +: 8] <= reg_wdata & IVMASK[8*b +: 8];
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)
        en_m[p] <= '0;
      else if (reg_we && reg_addr == MASK_BASE + 8'(16 * p))
        en_m[p] <= reg_wdata;
    end
    assign en_flat[8*p +: 8] = en_m[p];
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NB; b++)
      if (reg_addr == IV_BASE + 8'(b)) reg_rdata = ival_p[8*b +: 8];
    for (int p = 0; p < NPORTS; p++)
      if (reg_addr == MASK_BASE + 8'(16 * p)) reg_rdata = en_m[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic           f;
    logic [IVW-1:0] c;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f <= 1'b0;
        c <= '0;
      end else if (!en_flat[i] || s2[i] == f) begin
        f <= s2[i];
        c <= '0;
      end else if (c >= ival) begin
        f <= s2[i];
        c <= '0;
      end else if (tick) begin
        c <= c + 1'b1;
      end
    end
    assign filt[i] = f;
  end

  assign dout = (en_flat & filt) | (~en_flat & s2);
endmodule

module glitch_filter_chk #(
  parameter int NL = 96,
  parameter int IVW = 20,
  parameter int TICK_DIV = 10,
  parameter logic [7:0] IV_BASE = 8'h08,
  parameter logic [7:0] MASK_BASE = 8'h44
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [NL-1:0]  filt,
  input logic [NL-1:0]  s2,
  input logic [7:0]     en0,
  input logic [IVW-1:0] cnt0,
  input logic [IVW-1:0] ival,
  input logic           reg_we,
  input logic [7:0]     reg_addr,
  input logic [7:0]     reg_wdata
);
  if (TICK_DIV > 1) begin : g_tk
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R5
  end
  AST_FILT_TOWARD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt ^ $past(filt)) & (filt ^ $past(s2))) == '0); // R4
  AST_MATCH_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (en0[0] && filt[0] == s2[0]) |=> cnt0 == '0); // R5
  AST_HOLD_UNTIL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (en0[0] && filt[0] != s2[0] && cnt0 < ival) |=> filt[0] == $past(filt[0])); // R4
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == MASK_BASE) |=> en0 == $past(reg_wdata)); // R2
  AST_IVAL_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == IV_BASE) |=> ival[7:0] == $past(reg_wdata)); // R1
endmodule

bind glitch_filter glitch_filter_chk #(
  .NL(NL), .IVW(IVW), .TICK_DIV(TICK_DIV), .IV_BASE(IV_BASE), .MASK_BASE(MASK_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .filt(filt), .s2(s2),
  .en0(en_m[0]), .cnt0(g_line[0].c), .ival(ival),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/glitch_filter_bench.sv
module glitch_filter_bench;
  localparam int NP = 12;
  localparam int NL = NP * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NL-1:0] din = '0;
  logic [NL-1:0] dout;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  glitch_filter u_glitch_filter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din(din), .dout(dout)
  );

  task automatic check(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ival(int v);
    wr(8'h08, 8'(v));
    wr(8'h09, 8'(v >> 8));
    wr(8'h0A, 8'(v >> 16));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 dout after reset", dout, '0);
    rd(8'h08, d); check("R1 ival b0 reset", NL'(d), '0);
    rd(8'h0A, d); check("R1 ival b2 reset", NL'(d), '0);
    rd(8'h74, d); check("R2 mask3 reset", NL'(d), '0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    set_ival(32'hF2345);
    wr(8'h0A, 8'hF1);
    rd(8'h08, d); check("R1 ival b0", NL'(d), NL'(8'h45));
    rd(8'h09, d); check("R1 ival b1", NL'(d), NL'(8'h23));
    rd(8'h0A, d); check("R1 ival b2 upper nibble zero", NL'(d), NL'(8'h01));
    wr(8'hF4, 8'hA5);
    rd(8'hF4, d); check("R2 mask group 11", NL'(d), NL'(8'hA5));
    wr(8'h45, 8'hFF);
    rd(8'h45, d); check("R2 unmapped reads 0", NL'(d), '0);
    rd(8'h44, d); check("R2 mask0 untouched by unmapped write", NL'(d), '0);
    wr(8'hF4, 8'h00);
  endtask

  task automatic t_bypass();
    logic [NL-1:0] v;
    v = '0; v[8*2 +: 8] = 8'h3C;
    @(negedge clk); din = v;
    @(posedge clk); @(negedge clk);
    check("R3 bypass after one edge", dout, '0);
    @(posedge clk); @(negedge clk);
    check("R3 bypass after two edges", dout, v);
    @(negedge clk); din = '0;
    wait_cyc(3);
  endtask

  task automatic t_zero();
    logic [NL-1:0] v;
    set_ival(0);
    wr(8'h44, 8'hFF);
    v = '0; v[7:0] = 8'h81;
    @(negedge clk); din = v;
    wait_cyc(2);
    check("R6 interval 0 not yet at edge 2", dout, '0);
    wait_cyc(1);
    check("R6 interval 0 follows at edge 3", dout, v);
    @(negedge clk); din = '0;
    wait_cyc(4);
  endtask

  task automatic t_delay();
    logic [NL-1:0] v;
    set_ival(5);
    v = '0; v[0] = 1'b1; v[8*1] = 1'b1;
    @(negedge clk); din = v;
    wait_cyc(38);
    check("R4 held before 5 ticks", dout, {{(NL-9){1'b0}}, 9'h100});
    wait_cyc(22);
    check("R4 follows after 5 ticks", dout, v);
    @(negedge clk); din = '0;
    wait_cyc(65);
    check("R4 return edge filtered", dout, '0);
  endtask

  task automatic t_glitch();
    logic [NL-1:0] v;
    v = '0; v[3] = 1'b1;
    @(negedge clk); din = v;
    wait_cyc(25);
    check("R4 glitch mid-pulse", dout, '0);
    din = '0;
    wait_cyc(30);
    check("R5 glitch never seen, count restarted", dout, '0);
    din = v;
    wait_cyc(25);
    din = '0;
    wait_cyc(60);
    check("R5 repeated short pulses not summed", dout, '0);
  endtask

  task automatic t_shared();
    logic [NL-1:0] v;
    wr(8'h44, 8'h00);
    wr(8'h74, 8'h02);
    wr(8'hD4, 8'h40);
    set_ival(3);
    v = '0; v[8*3+1] = 1'b1; v[8*9+6] = 1'b1;
    @(negedge clk); din = v;
    wait_cyc(18);
    check("R7 both groups held", dout, '0);
    wait_cyc(27);
    check("R7 both groups follow", dout, v);
    @(negedge clk); din = '0;
    wait_cyc(50);
    check("R7 both groups return", dout, '0);
    wr(8'h74, 8'h00);
    wr(8'hD4, 8'h00);
  endtask

  task automatic t_rewrite();
    logic [NL-1:0] v;
    wr(8'h44, 8'h10);
    set_ival(100);
    v = '0; v[4] = 1'b1;
    @(negedge clk); din = v;
    wait_cyc(30);
    check("R8 pending under long interval", dout, '0);
    wr(8'h08, 8'h01);
    check("R8 no change in write cycle", dout, '0);
    wait_cyc(1);
    check("R8 new interval used next compare", dout, v);
    @(negedge clk); din = '0;
    wait_cyc(30);
    wr(8'h44, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bypass();
    t_zero();
    t_delay();
    t_glitch();
    t_shared();
    t_rewrite();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule